// File: doc/BRIEF.md
# Bus Master Front-End Handshake

This block sits between a simple local request port and a pipelined system bus with separate address and data phases. The local logic raises a valid flag and presents a beat: direction, address, a beat count and a last marker. The block forwards the valid flag as the bus request. It answers with one-cycle strobes. The address strobe tells the local logic that the presented beat has been taken and the next one may be shown. The write strobe tells it to present that beat's write data in the following cycle. The read strobe marks the cycle in which read data on the local side is valid.

On the bus side the block registers the address, direction and transfer type. It uses grant and ready to decide when a beat may move. Ready low freezes every bus output. A data phase always follows its address phase by exactly one completed bus cycle. A sequence opens with a NONSEQ beat and continues with SEQ beats. It closes on the last marker, or when a nonzero beat count runs out.

Top module: `bmf_frontend`

## Requirements
- R1: `bus_req` equals `loc_valid` in every cycle.
- R2: `take_addr` is high exactly when `bus_grant`, `bus_ready` and `loc_valid` are all high. The clock edge ending such a cycle loads `bus_addr` with `loc_addr` and `bus_write` with `loc_write`.
- R3: `take_wdata` is high exactly when `take_addr` is high and `loc_write` is high. The local port presents the write data in the next cycle, and it appears on `bus_wdata` throughout the data phase that follows that beat's address phase.
- R4: `rdata_strobe` is high exactly in cycles where `bus_ready` is high and the current data phase belongs to a read beat. `loc_rdata` then carries `bus_rdata`.
- R5: `bus_trans` uses IDLE=2'b00, NONSEQ=2'b10 and SEQ=2'b11. The first beat of a sequence is driven as NONSEQ and each later beat as SEQ.
- R6: When `bus_ready` is high and no address strobe occurs, the next `bus_trans` is IDLE. This covers a grant with no pending request. `bus_trans` is also IDLE after reset.
- R7: A beat taken with `loc_last` high closes the sequence, so the next beat taken is NONSEQ.
- R8: `loc_len` is sampled on the first beat of a sequence. A nonzero value N closes the sequence after N beats even if `loc_last` stays low. Zero means the count is open and only `loc_last` closes the sequence.
- R9: While `bus_ready` is low, `bus_addr`, `bus_write`, `bus_trans` and `bus_wdata` hold their values and no address or read strobe is given.
- R10: While `bus_grant` is low, no address strobe is given. A sequence in progress resumes with SEQ beats once grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_valid | input | 1 | Local beat request valid |
| loc_write | input | 1 | Beat direction, 1 = write |
| loc_addr | input | AW | Beat address |
| loc_wdata | input | DW | Write data, presented the cycle after `take_wdata` |
| loc_len | input | LW | Beats in the sequence, 0 = open count |
| loc_last | input | 1 | Marks the final beat of a sequence |
| loc_rdata | output | DW | Read data toward local logic |
| take_addr | output | 1 | Address strobe: beat accepted |
| take_wdata | output | 1 | Write strobe: present write data next cycle |
| rdata_strobe | output | 1 | Read data valid on `loc_rdata` |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| bus_ready | input | 1 | Bus ready, low extends the current phase |
| bus_addr | output | AW | Bus address |
| bus_write | output | 1 | Bus direction |
| bus_trans | output | 2 | Transfer type |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |

## Verification
In a pipelined stream, the address strobe for one beat and the data phase of an earlier beat fall in the same cycle. For reads that cycle carries both `take_addr` and `rdata_strobe`. For writes, new local write data arrives while the previous beat's data is still on the bus. The bench provokes this with back-to-back bursts under steady and pseudo-random ready and grant, including ready dropping in the cycle after a write strobe. A scoreboard checks each address phase against the beat the local side handed over. It then checks the matching data phase one bus cycle later: write data against the beat's value, read data against a function of the address.

// File: rtl/bmf_pkg.sv
// Shared types for the bus master front-end.
package bmf_pkg;
    // Transfer type codes driven on the bus.
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;
endpackage

// File: rtl/bmf_seq.sv
// Sequence tracker: decides whether the beat being taken opens a sequence
// and whether it closes one, using the last marker or a beat count.
// Assumes take is only asserted in a cycle where the bus accepts a beat.
module bmf_seq #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          last_in,
    input  logic [LW-1:0] len_in,
    output logic          first_beat
);
    logic          in_seq_q;
    logic          len_def_q;
    logic [LW-1:0] rem_q;
    logic          len_def_now;
    logic [LW-1:0] rem_now;
    logic          closes;

    // Pick the count source: fresh from the port on a first beat, stored otherwise.
    always_comb begin
        len_def_now = in_seq_q ? len_def_q : (len_in != '0);
        rem_now     = in_seq_q ? rem_q : len_in;
        closes      = last_in || (len_def_now && (rem_now == LW'(1)));
        first_beat  = !in_seq_q;
    end

    // Advance the sequence state on every accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_seq_q  <= 1'b0;
            len_def_q <= 1'b0;
            rem_q     <= '0;
        end else if (take) begin
            if (closes) begin
                in_seq_q <= 1'b0;
            end else begin
                in_seq_q  <= 1'b1;
                len_def_q <= len_def_now;
                rem_q     <= len_def_now ? rem_now - LW'(1) : rem_q;
            end
        end
    end

    assert_last_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_in) |=> first_beat);

    assert_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_beat && len_def_q) |-> (rem_q != '0));
endmodule

// File: rtl/bmf_addr_stage.sv
// Address stage: registers address, direction and transfer type for the bus.
// Holds everything while ready is low. Drives IDLE when a ready cycle
// passes without a taken beat.
module bmf_addr_stage
    import bmf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready,
    input  logic          take,
    input  logic          first_beat,
    input  logic [AW-1:0] addr_in,
    input  logic          write_in,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output trans_e        bus_trans
);
    // Load a new address phase on each taken beat, otherwise go idle when ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_write <= 1'b0;
            bus_trans <= TR_IDLE;
        end else if (ready) begin
            if (take) begin
                bus_addr  <= addr_in;
                bus_write <= write_in;
                bus_trans <= first_beat ? TR_NONSEQ : TR_SEQ;
            end else begin
                bus_trans <= TR_IDLE;
            end
        end
    end

    assert_addr_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (bus_addr == $past(addr_in)) && (bus_write == $past(write_in)));

    assert_first_nonseq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && first_beat) |=> (bus_trans == TR_NONSEQ));

    assert_follow_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !first_beat) |=> (bus_trans == TR_SEQ));

    assert_idle_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !take) |=> (bus_trans == TR_IDLE));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(bus_addr) && $stable(bus_write) && $stable(bus_trans));
endmodule

// File: rtl/bmf_data_stage.sv
// Data stage: stages local write data presented the cycle after a write
// strobe, moves it onto the bus when the address phase completes, and
// tracks the data phase to flag valid read data.
// Assumes at most one write beat awaits its data phase at a time.
module bmf_data_stage
    import bmf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready,
    input  logic          wtake,
    input  logic [DW-1:0] wdata_in,
    input  trans_e        addr_trans,
    input  logic          addr_write,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] bus_wdata,
    output logic          rdata_strobe,
    output logic [DW-1:0] loc_rdata
);
    logic          wtake_d;
    logic [DW-1:0] wstage_q;
    logic [DW-1:0] wsel;
    logic          addr_active;
    logic          dph_valid_q;
    logic          dph_write_q;

    // Choose the live local data in the cycle after the strobe, staged data later.
    always_comb begin
        wsel        = wtake_d ? wdata_in : wstage_q;
        addr_active = (addr_trans == TR_NONSEQ) || (addr_trans == TR_SEQ);
    end

    // Remember that write data is due from the local side this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) wtake_d <= 1'b0;
        else        wtake_d <= wtake;
    end

    // Capture the local write data in case the address phase is stretched.
    always_ff @(posedge clk) begin
        if (!rst_n)       wstage_q <= '0;
        else if (wtake_d) wstage_q <= wdata_in;
    end

    // Start a data phase when an active address phase completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dph_valid_q <= 1'b0;
            dph_write_q <= 1'b0;
            bus_wdata   <= '0;
        end else if (ready) begin
            dph_valid_q <= addr_active;
            dph_write_q <= addr_write;
            if (addr_active && addr_write) bus_wdata <= wsel;
        end
    end

    // Flag read data in a completing read data phase.
    always_comb begin
        rdata_strobe = ready && dph_valid_q && !dph_write_q;
        loc_rdata    = bus_rdata;
    end

    assert_wdata_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wtake_d && ready && addr_active && addr_write) |=> (bus_wdata == $past(wdata_in)));

    assert_read_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && addr_active && !addr_write) |=> (rdata_strobe == ready));

    assert_wdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(bus_wdata));
endmodule

// File: rtl/bmf_frontend.sv
// Bus master front-end: turns a local valid/beat interface into a
// pipelined bus master. Address strobe = grant & ready & valid, write strobe
// adds the direction, read strobe marks completing read data phases.
// Assumes the local side holds a beat until its address strobe and shows
// write data exactly in the cycle after the write strobe.
module bmf_frontend
    import bmf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_valid,
    input  logic          loc_write,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    input  logic [LW-1:0] loc_len,
    input  logic          loc_last,
    output logic [DW-1:0] loc_rdata,
    output logic          take_addr,
    output logic          take_wdata,
    output logic          rdata_strobe,
    output logic          bus_req,
    input  logic          bus_grant,
    input  logic          bus_ready,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [1:0]    bus_trans,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    logic   first_beat;
    trans_e trans_q;

    // Request and handshake strobes.
    always_comb begin
        bus_req    = loc_valid;
        take_addr  = bus_grant && bus_ready && loc_valid;
        take_wdata = take_addr && loc_write;
        bus_trans  = trans_q;
    end

    bmf_seq #(.LW(LW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take_addr),
        .last_in    (loc_last),
        .len_in     (loc_len),
        .first_beat (first_beat)
    );

    bmf_addr_stage #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (bus_ready),
        .take       (take_addr),
        .first_beat (first_beat),
        .addr_in    (loc_addr),
        .write_in   (loc_write),
        .bus_addr   (bus_addr),
        .bus_write  (bus_write),
        .bus_trans  (trans_q)
    );

    bmf_data_stage #(.DW(DW)) u_data (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready        (bus_ready),
        .wtake        (take_wdata),
        .wdata_in     (loc_wdata),
        .addr_trans   (trans_q),
        .addr_write   (bus_write),
        .bus_rdata    (bus_rdata),
        .bus_wdata    (bus_wdata),
        .rdata_strobe (rdata_strobe),
        .loc_rdata    (loc_rdata)
    );

    assert_no_take_without_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_grant && loc_valid) |=> ($past(bus_ready) ? (bus_trans == 2'b00) : $stable(bus_trans)));
endmodule

// File: tb/bmf_frontend_test.sv
module bmf_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          loc_valid = 1'b0, loc_write = 1'b0, loc_last = 1'b0;
    logic [AW-1:0] loc_addr = '0;
    logic [DW-1:0] loc_wdata = '0;
    logic [LW-1:0] loc_len = '0;
    logic [DW-1:0] loc_rdata;
    logic          take_addr, take_wdata, rdata_strobe, bus_req;
    logic          bus_grant = 1'b1, bus_ready = 1'b1;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic [1:0]    bus_trans;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    bmf_frontend #(.AW(AW), .DW(DW), .LW(LW)) uut (
        .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_write(loc_write),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_len(loc_len),
        .loc_last(loc_last), .loc_rdata(loc_rdata), .take_addr(take_addr),
        .take_wdata(take_wdata), .rdata_strobe(rdata_strobe), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_trans(bus_trans), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wr;
        logic [DW-1:0] data;
        logic [LW-1:0] len;
        logic          last;
    } beat_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wr;
        logic [DW-1:0] data;
        logic [1:0]    trans;
        logic [3:0]    tag;
    } exp_t;

    beat_t pend_q[$];
    exp_t  exp_q[$];
    int    checks = 0;
    int    fails = 0;
    int    mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic  took_n = 1'b0;

    // bench model of sequence state
    logic          m_in_seq = 1'b0;
    logic          m_def = 1'b0;
    logic [LW-1:0] m_rem = '0;
    logic [3:0]    m_close_tag = 4'd5;

    // data-phase tracking for the monitor
    logic          dp_valid = 1'b0;
    exp_t          dp;
    // bench slave
    logic          s_valid = 1'b0;
    logic [AW-1:0] s_addr = '0;
    // hold snapshot
    logic          was_stalled = 1'b0;
    logic [AW-1:0] snap_addr;
    logic          snap_write;
    logic [1:0]    snap_trans;
    logic [DW-1:0] snap_wdata;

    function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h5A5A_0000;
    endfunction

    function automatic string tag_s(input logic [3:0] t);
        case (t)
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd10:   return "R10";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    assign bus_rdata = s_valid ? rd_fn(s_addr) : 32'hBAD0_BAD0;

    // bench slave: latch address phase on completion
    always @(posedge clk) begin
        if (!rst_n) s_valid <= 1'b0;
        else if (bus_ready) begin
            s_valid <= (bus_trans == 2'b10) || (bus_trans == 2'b11);
            s_addr  <= bus_addr;
        end
    end

    // local master and bus-side stimulus, driven just after each edge
    always @(posedge clk) begin
        beat_t h;
        exp_t  e;
        logic  closes;
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        loc_wdata = 32'hDEAD_0000 ^ {16'h0, lfsr};
        if (took_n && pend_q.size() != 0) begin
            h = pend_q.pop_front();
            if (!m_in_seq) begin
                e.trans = 2'b10;
                e.tag   = m_close_tag;
                m_def   = (h.len != '0);
                m_rem   = h.len;
            end else begin
                e.trans = 2'b11;
                e.tag   = (mode == 2) ? 4'd10 : 4'd5;
            end
            if (m_def) m_rem = m_rem - 1'b1;
            closes = h.last || (m_def && m_rem == '0);
            if (closes) m_close_tag = h.last ? 4'd7 : 4'd8;
            m_in_seq = !closes;
            e.addr = h.addr;
            e.wr   = h.wr;
            e.data = h.data;
            exp_q.push_back(e);
            if (h.wr) loc_wdata = h.data;
        end
        took_n = 1'b0;
        loc_valid = (pend_q.size() != 0);
        if (pend_q.size() != 0) begin
            loc_addr  = pend_q[0].addr;
            loc_write = pend_q[0].wr;
            loc_len   = pend_q[0].len;
            loc_last  = pend_q[0].last;
        end else begin
            loc_addr = lfsr; loc_write = lfsr[0]; loc_len = '0; loc_last = 1'b0;
        end
        case (mode)
            1:       begin bus_grant = 1'b1;    bus_ready = lfsr[3] | lfsr[7]; end
            2:       begin bus_grant = lfsr[2] | lfsr[9]; bus_ready = 1'b1; end
            3:       begin bus_grant = lfsr[1] | lfsr[5]; bus_ready = lfsr[4] | lfsr[11]; end
            default: begin bus_grant = 1'b1;    bus_ready = 1'b1; end
        endcase
    end

    // monitor / scoreboard, sampled mid-cycle
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            check(bus_req == loc_valid, "R1", "bus_req", bus_req, loc_valid);
            check(take_addr == (bus_grant && bus_ready && loc_valid), "R2", "take_addr",
                  take_addr, bus_grant && bus_ready && loc_valid);
            check(take_wdata == (take_addr && loc_write), "R3", "take_wdata",
                  take_wdata, take_addr && loc_write);
            if (!bus_grant)
                check(!take_addr, "R10", "strobe without grant", take_addr, 0);
            if (was_stalled) begin
                check(bus_addr == snap_addr && bus_write == snap_write &&
                      bus_trans == snap_trans && bus_wdata == snap_wdata, "R9", "hold",
                      {bus_addr, bus_trans, bus_wdata[15:0]}, {snap_addr, snap_trans, snap_wdata[15:0]});
                check(!take_addr && !rdata_strobe || bus_ready, "R9", "strobe in stall",
                      {take_addr, rdata_strobe}, 0);
            end
            // data phase
            if (dp_valid) begin
                if (dp.wr)
                    check(bus_wdata == dp.data, "R3", "bus_wdata", bus_wdata, dp.data);
                else if (bus_ready) begin
                    check(rdata_strobe, "R4", "rdata_strobe", rdata_strobe, 1);
                    check(loc_rdata == rd_fn(dp.addr), "R4", "loc_rdata", loc_rdata, rd_fn(dp.addr));
                end
                if (bus_ready) dp_valid = 1'b0;
            end else if (bus_ready) begin
                check(!rdata_strobe, "R4", "stray rdata_strobe", rdata_strobe, 0);
            end
            // address phase
            if (bus_trans != 2'b00) begin
                if (bus_ready) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R6", "unexpected transfer", bus_trans, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(bus_addr == e.addr, "R2", "bus_addr", bus_addr, e.addr);
                        check(bus_write == e.wr, "R2", "bus_write", bus_write, e.wr);
                        check(bus_trans == e.trans, tag_s(e.tag), "bus_trans", bus_trans, e.trans);
                        dp = e;
                        dp_valid = 1'b1;
                    end
                end
            end else if (bus_ready) begin
                check(exp_q.size() == 0, "R6", "idle with beat pending", exp_q.size(), 0);
            end
            was_stalled = !bus_ready;
            snap_addr = bus_addr; snap_write = bus_write;
            snap_trans = bus_trans; snap_wdata = bus_wdata;
            took_n = take_addr;
        end
    end

    task automatic push_burst(input logic [AW-1:0] base, input int n, input bit wr,
                              input int len, input bit use_last);
        beat_t b;
        @(posedge clk); #2;
        for (int i = 0; i < n; i++) begin
            b.addr = base + AW'(4 * i);
            b.wr   = wr;
            b.data = {base, 16'(i)} ^ 32'h1357_0000;
            b.len  = LW'(len);
            b.last = use_last && (i == n - 1);
            pend_q.push_back(b);
        end
    endtask

    task automatic wait_drain;
        while (pend_q.size() != 0 || exp_q.size() != 0 || dp_valid) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bus_trans == 2'b00, "R6", "reset trans", bus_trans, 0);
        check(bus_addr == '0 && bus_wdata == '0, "R6", "reset bus", bus_addr, 0);
        check(!take_addr && !rdata_strobe && !bus_req, "R1", "reset strobes",
              {take_addr, rdata_strobe, bus_req}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        // grant with nothing requested: must stay IDLE (R6)
        repeat (6) @(posedge clk);
        mode = 0;
        push_burst(16'h0100, 1, 1'b1, 1, 1'b1);          // single write
        push_burst(16'h0200, 1, 1'b0, 1, 1'b1);          // single read
        push_burst(16'h0300, 4, 1'b1, 4, 1'b1);          // counted write burst
        push_burst(16'h0400, 6, 1'b0, 0, 1'b1);          // open-count read burst, R7
        wait_drain();
        push_burst(16'h0500, 6, 1'b0, 3, 1'b0);          // R8: two sequences of 3
        push_burst(16'h0600, 5, 1'b1, 0, 1'b1);
        wait_drain();
        mode = 1;                                        // R9 stalls
        push_burst(16'h1000, 8, 1'b1, 8, 1'b1);
        push_burst(16'h1100, 8, 1'b0, 0, 1'b1);
        wait_drain();
        mode = 2;                                        // R10 grant loss
        push_burst(16'h2000, 8, 1'b0, 8, 1'b1);
        push_burst(16'h2100, 8, 1'b1, 0, 1'b1);
        wait_drain();
        mode = 3;
        for (int k = 0; k < 12; k++)
            push_burst(16'h3000 + 16'(k * 64), 1 + (k % 5), k[0], (k % 3 == 0) ? 0 : 1 + (k % 5), 1'b1);
        wait_drain();
        mode = 0;
        repeat (5) @(posedge clk);
        check(exp_q.size() == 0 && pend_q.size() == 0, "R2", "queues drained",
              exp_q.size() + pend_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule